// File: doc/BRIEF.md
# Weighted Scan Test-Enable Generator

This block is the pattern source of a low-power scan self-test controller. A 16-bit pseudorandom register advances once per clock. A small XOR network turns its state into one scan-in bit per scan tree, and every chain of a tree takes that same bit. Each chain also gets its own test-enable bit. In the pseudorandom phase that bit is a biased random draw, so a chain shifts with a programmed probability and captures otherwise. The number of shift and capture cycles in a test cycle therefore varies from one test cycle to the next.

A chain can be switched off for the pseudorandom phase. A switched-off chain sees a fixed scan-in constant and a test enable of 0, so its flops do not toggle. In the deterministic phase the weighting and the chain mask are bypassed. Every chain then follows one shared test-enable input and takes its tree's scan-in stream.

A new seed is written into a shadow register while the generator keeps running. A one-cycle load strobe moves the shadow contents into the generator at the next clock. Both outputs are combinational functions of the generator state and the configuration pins. The block runs freely on every clock and offers no back-pressure. A consumer that is not ready must gate its own use of the outputs.

Top module: `wtp_scan_source`

## Requirements
- R1: During and right after reset, the generator state and the shadow register both hold 16'hACE1.
- R2: On each clock without a load, the state s steps as a right-shifting Galois register: next = (s >> 1) XOR (s[0] ? 16'hB400 : 0). The state is never zero.
- R3: The scan-in of tree t is s[t] ^ s[(t+5)%16] ^ s[(t+11)%16]. Chain c belongs to tree c / CHAINS_PER_TREE, and every active chain of a tree carries its tree's bit.
- R4: In phase 0, an enabled chain c draws d = {s[(3c+2)%16], s[(3c+1)%16], s[3c%16]}. Its test enable is 1 exactly when d < 4 + w, where w = chain_wcode[2c+1:2c]. Codes 0 to 3 therefore give shift probabilities of 4/8 to 7/8, and a draw below 4 always shifts.
- R5: In phase 0, a chain with chain_on[c] = 0 has test enable 0 and scan-in chain_const[c]. Its outputs do not change while the configuration is unchanged.
- R6: In phase 1, every chain's test enable equals det_te and its scan-in equals its tree's bit. chain_on, chain_const and chain_wcode have no effect.
- R7: shadow_wr captures shadow_data into the shadow register on the clock. The write does not disturb the running sequence.
- R8: A seed_load high at a clock loads the shadow value held before that clock into the state. A shadow value of zero loads 16'hACE1 instead. A write in the same cycle affects only later loads.
- R9: In phase 0 over 4096 cycles, each enabled chain shifts in a fraction of cycles within ±0.03 of (4+w)/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | 0 = weighted pseudorandom, 1 = deterministic |
| det_te | input | 1 | Shared test enable used in phase 1 |
| shadow_wr | input | 1 | Write strobe for the shadow seed register |
| shadow_data | input | 16 | Seed value to write |
| seed_load | input | 1 | Move shadow into the generator at the next clock |
| chain_on | input | NUM_CHAINS | Per-chain enable for phase 0 |
| chain_const | input | NUM_CHAINS | Frozen scan-in value of a disabled chain |
| chain_wcode | input | NUM_CHAINS*WCODE_W | Per-chain weight code, chain c at [2c+1:2c] |
| chain_si | output | NUM_CHAINS | Scan-in bit per chain |
| chain_te | output | NUM_CHAINS | Test enable per chain (1 = shift, 0 = capture) |

## Verification
A corrupted generator state shows on the same cycle in both the tree scan-in bits and the phase-0 enable draws. Because each state is a bijective step of the previous one, the error persists on every later cycle until the next seed load. A reload that takes the wrong shadow value, or reloads one cycle late, gives a mismatch on the first cycle after the strobe. A wrong weight comparison is rarely visible in any single cycle. It appears in the per-chain shift counts over a few thousand cycles, and directly when a draw below half still yields a capture.

// File: rtl/wtp_pkg.sv
package wtp_pkg;
  localparam int unsigned LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t GALOIS_MASK  = 16'hB400;
  localparam lfsr_t DEFAULT_SEED = 16'hACE1;

  function automatic lfsr_t lfsr_step(input lfsr_t s);
    lfsr_t n;
    n = s >> 1;
    if (s[0]) n = n ^ GALOIS_MASK;
    return n;
  endfunction

  // three-tap XOR mask for one phase-shifter output
  function automatic lfsr_t ps_mask(input int unsigned t, input int unsigned oa,
                                    input int unsigned ob);
    lfsr_t m;
    m = '0;
    m[t % LFSR_W]        = 1'b1;
    m[(t + oa) % LFSR_W] = m[(t + oa) % LFSR_W] ^ 1'b1;
    m[(t + ob) % LFSR_W] = m[(t + ob) % LFSR_W] ^ 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wtp_lfsr.sv
module wtp_lfsr
  import wtp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shadow_wr,
  input  lfsr_t shadow_data,
  input  logic  seed_load,
  output lfsr_t state_o
);
  lfsr_t state_q, shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= DEFAULT_SEED;
      shadow_q <= DEFAULT_SEED;
    end else begin
      if (shadow_wr) shadow_q <= shadow_data;
      if (seed_load) state_q <= (shadow_q == '0) ? DEFAULT_SEED : shadow_q;
      else           state_q <= lfsr_step(state_q);
    end
  end

  assign state_o = state_q;

  assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_reload_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && shadow_q != '0) |=> state_q == $past(shadow_q));
  assert_reload_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && shadow_q == '0) |=> state_q == DEFAULT_SEED);
  assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_wr |=> shadow_q == $past(shadow_data));
endmodule

// File: rtl/wtp_phase_shifter.sv
module wtp_phase_shifter
  import wtp_pkg::*;
#(
  parameter int unsigned NUM_TREES = 4,
  parameter int unsigned OFS_A     = 5,
  parameter int unsigned OFS_B     = 11
) (
  input  lfsr_t                state_i,
  output logic [NUM_TREES-1:0] tree_bit_o
);
  for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
    localparam lfsr_t TAPS = ps_mask(t, OFS_A, OFS_B);
    assign tree_bit_o[t] = ^(state_i & TAPS);
  end
endmodule

// File: rtl/wtp_chain_gate.sv
module wtp_chain_gate #(
  parameter int unsigned WCODE_W = 2,
  localparam int unsigned RAND_W = WCODE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase,
  input  logic               det_te,
  input  logic               on,
  input  logic               cst,
  input  logic [WCODE_W-1:0] wcode,
  input  logic [RAND_W-1:0]  draw,
  input  logic               tree_bit,
  output logic               si,
  output logic               te
);
  logic [RAND_W-1:0] threshold;
  logic              shift_hit;

  assign threshold = {1'b1, wcode};
  assign shift_hit = draw < threshold;

  always_comb begin
    if (phase) begin
      te = det_te;
      si = tree_bit;
    end else if (!on) begin
      te = 1'b0;
      si = cst;
    end else begin
      te = shift_hit;
      si = tree_bit;
    end
  end

  // weight is never below one half: a low draw always shifts
  assert_half_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && on && !draw[RAND_W-1]) |-> te);
  assert_top_draw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && on && (&draw)) |-> !te);
endmodule

// File: rtl/wtp_scan_source.sv
module wtp_scan_source
  import wtp_pkg::*;
#(
  parameter int unsigned NUM_TREES       = 4,
  parameter int unsigned CHAINS_PER_TREE = 2,
  parameter int unsigned WCODE_W         = 2,
  localparam int unsigned NUM_CHAINS     = NUM_TREES * CHAINS_PER_TREE,
  localparam int unsigned RAND_W         = WCODE_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          phase,
  input  logic                          det_te,
  input  logic                          shadow_wr,
  input  logic [LFSR_W-1:0]             shadow_data,
  input  logic                          seed_load,
  input  logic [NUM_CHAINS-1:0]         chain_on,
  input  logic [NUM_CHAINS-1:0]         chain_const,
  input  logic [NUM_CHAINS*WCODE_W-1:0] chain_wcode,
  output logic [NUM_CHAINS-1:0]         chain_si,
  output logic [NUM_CHAINS-1:0]         chain_te
);
  lfsr_t                state;
  logic [NUM_TREES-1:0] tree_bit;

  wtp_lfsr u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .shadow_wr  (shadow_wr),
    .shadow_data(shadow_data),
    .seed_load  (seed_load),
    .state_o    (state)
  );

  wtp_phase_shifter #(.NUM_TREES(NUM_TREES), .OFS_A(5), .OFS_B(11)) u_ps (
    .state_i   (state),
    .tree_bit_o(tree_bit)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int unsigned TREE = c / CHAINS_PER_TREE;
    localparam int unsigned BASE = c * RAND_W;
    logic [RAND_W-1:0] draw;

    always_comb begin
      for (int b = 0; b < RAND_W; b++) draw[b] = state[(BASE + b) % LFSR_W];
    end

    wtp_chain_gate #(.WCODE_W(WCODE_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .det_te  (det_te),
      .on      (chain_on[c]),
      .cst     (chain_const[c]),
      .wcode   (chain_wcode[c*WCODE_W +: WCODE_W]),
      .draw    (draw),
      .tree_bit(tree_bit[TREE]),
      .si      (chain_si[c]),
      .te      (chain_te[c])
    );

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase && !chain_on[c]) |-> (!chain_te[c] && chain_si[c] == chain_const[c]));
    assert_disabled_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase && !chain_on[c] && $past(!phase && !chain_on[c]) && $stable(chain_const))
      |-> $stable(chain_si[c]) && $stable(chain_te[c]));
    assert_det_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      phase |-> chain_te[c] == det_te);
    if ((c % CHAINS_PER_TREE) != 0) begin : g_peer
      assert_tree_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> chain_si[c] == chain_si[c-1]);
    end
  end
endmodule

// File: tb/wtp_scan_source_tb.sv
module wtp_scan_source_tb;
  localparam int NC = 8;
  localparam int NT = 4;
  localparam int CPT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase = 1'b0, det_te = 1'b0, shadow_wr = 1'b0, seed_load = 1'b0;
  logic [15:0] shadow_data = '0;
  logic [NC-1:0] chain_on = '1, chain_const = '0;
  logic [2*NC-1:0] chain_wcode = '0;
  logic [NC-1:0] chain_si, chain_te;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_state = 16'hACE1, m_shadow = 16'hACE1;

  always #10 clk = ~clk;

  wtp_scan_source u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .det_te(det_te),
    .shadow_wr(shadow_wr), .shadow_data(shadow_data), .seed_load(seed_load),
    .chain_on(chain_on), .chain_const(chain_const), .chain_wcode(chain_wcode),
    .chain_si(chain_si), .chain_te(chain_te)
  );

  // {phase, det_te, chain_on, chain_const, chain_wcode}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hFF, 8'h00, 16'h0000},
    {1'b0, 1'b0, 8'hFF, 8'h00, 16'hFFFF},
    {1'b0, 1'b1, 8'h5A, 8'hC3, 16'h1BE4},
    {1'b0, 1'b0, 8'h00, 8'hA5, 16'h9C36},
    {1'b1, 1'b1, 8'h00, 8'h3C, 16'h0000},
    {1'b1, 1'b0, 8'hF0, 8'hFF, 16'hFFFF}
  };

  function automatic logic [15:0] step_fn(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  task automatic expected(output logic [NC-1:0] te, output logic [NC-1:0] si);
    for (int c = 0; c < NC; c++) begin
      int t;
      logic tb_bit;
      logic [2:0] d;
      t = c / CPT;
      tb_bit = m_state[t] ^ m_state[(t+5)%16] ^ m_state[(t+11)%16];
      d = {m_state[(3*c+2)%16], m_state[(3*c+1)%16], m_state[(3*c)%16]};
      if (phase) begin
        te[c] = det_te; si[c] = tb_bit;
      end else if (!chain_on[c]) begin
        te[c] = 1'b0; si[c] = chain_const[c];
      end else begin
        te[c] = ({1'b0, d} < (4'd4 + {2'b00, chain_wcode[2*c +: 2]}));
        si[c] = tb_bit;
      end
    end
  endtask

  task automatic check_out(input string req);
    logic [NC-1:0] ete, esi;
    expected(ete, esi);
    tests++;
    if (chain_te !== ete) begin
      fails++;
      $display("FAIL %s te actual=%h expected=%h", req, chain_te, ete);
    end
    tests++;
    if (chain_si !== esi) begin
      fails++;
      $display("FAIL %s si actual=%h expected=%h", req, chain_si, esi);
    end
  endtask

  // one clock: model follows the inputs held over the edge
  task automatic step();
    @(posedge clk);
    if (seed_load) m_state = (m_shadow == 16'h0) ? 16'hACE1 : m_shadow;
    else           m_state = step_fn(m_state);
    if (shadow_wr) m_shadow = shadow_data;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state visible through the outputs
    repeat (3) @(negedge clk);
    check_out("R1 reset");
    rst_n = 1'b1;
    check_out("R1 after release");

    // table walk: R2/R3/R4/R5/R6
    foreach (VEC[i]) begin
      {phase, det_te, chain_on, chain_const, chain_wcode} = VEC[i];
      #1;
      for (int k = 0; k < 12; k++) begin
        check_out(phase ? "R6 R3 table" : "R4 R5 R2 table");
        step();
      end
    end

    // R5: disabled chains stay frozen while others run
    phase = 0; chain_on = 8'h0F; chain_const = 8'h90; chain_wcode = 16'h5555;
    #1;
    for (int k = 0; k < 6; k++) begin
      tests++;
      if (chain_te[7:4] !== 4'h0 || chain_si[7:4] !== 4'h9) begin
        fails++;
        $display("FAIL R5 frozen actual te=%h si=%h expected te=0 si=9",
                 chain_te[7:4], chain_si[7:4]);
      end
      step();
    end

    // R7: shadow write alone does not disturb the sequence
    chain_on = 8'hFF; chain_wcode = 16'h0000;
    shadow_wr = 1; shadow_data = 16'h1234;
    step();
    shadow_wr = 0;
    for (int k = 0; k < 5; k++) begin
      check_out("R7 no disturb");
      step();
    end

    // R8: load moves shadow into the state
    seed_load = 1;
    step();
    seed_load = 0;
    check_out("R8 load 1234");
    step();
    check_out("R8 after load");

    // R8: zero shadow falls back to default seed
    shadow_wr = 1; shadow_data = 16'h0000;
    step();
    shadow_wr = 0; seed_load = 1;
    step();
    seed_load = 0;
    check_out("R8 zero shadow");

    // R8: write and load in one cycle -> old shadow loaded
    shadow_wr = 1; shadow_data = 16'h5A5A;
    step();
    shadow_data = 16'hFFFF; seed_load = 1;
    step();
    shadow_wr = 0; seed_load = 0;
    check_out("R8 same-cycle old");
    seed_load = 1;
    step();
    seed_load = 0;
    check_out("R8 same-cycle new");

    // R9: shift fraction per chain
    begin
      int cnt [NC];
      phase = 0; chain_on = 8'hFF; chain_wcode = 16'h1BE4;
      #1;
      foreach (cnt[c]) cnt[c] = 0;
      for (int k = 0; k < 4096; k++) begin
        for (int c = 0; c < NC; c++) if (chain_te[c]) cnt[c]++;
        step();
      end
      for (int c = 0; c < NC; c++) begin
        int ex, df;
        ex = (4 + int'(chain_wcode[2*c +: 2])) * 512;
        df = cnt[c] - ex;
        tests++;
        if (df > 122 || df < -122) begin
          fails++;
          $display("FAIL R9 chain %0d shifts actual=%0d expected=%0d", c, cnt[c], ex);
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule